// File: doc/BRIEF.md
# Bus clock divider parameter search

This block picks the settings of a two-level serial bus clock prescaler. Given the frequency of the clock that feeds the bus controller and the bus rate wanted, it works out the division ratio that would be needed, derives a glitch-filter sampling value from the source clock, and then walks every pair of coarse and fine prescaler settings. For each pair it forms the divider that the pair would really produce, including a correction that grows with the filter value. It keeps the smallest divider that is still above the target, so the bus never runs faster than asked.

A request is made by pulsing `start` with both frequencies on the inputs. The block captures them and works through its sequence alone. One shared iterative divider handles every division: the target ratio, the filter value and the final bus rate. When the search ends, the block presents the packed prescaler code, the filter value, the chosen divider and the resulting bus rate, and raises `done` for one cycle. The results stay on the outputs until the next request completes.

Top module: `sclk_div_search`

## Requirements
- R1: The search target is the source frequency divided by the bus frequency (integer quotient), saturated to 65535; a bus frequency of zero gives a target of 65535.
- R2: The filter value output equals the source frequency divided by 20,000,000, integer quotient, saturated to 255.
- R3: Candidates are visited with the coarse step `a` running 10, 12, ... 30 (coarse index 4, 5, ... 14) in the outer order and the fine index `g` running 0 to 7 in the inner order. With `b = 16 << g` and `f` the filter value, each candidate divider is `b * (a + 2 * floor(3f / b))`.
- R4: A candidate is taken only when it is strictly above the target and strictly below the best divider kept so far. On equal dividers, the earlier candidate in R3 order stays.
- R5: The 8-bit code output packs the chosen pair as bits 1:0 = coarse index bits 1:0, bits 4:2 = fine index, bit 5 = coarse index bit 2, and bits 7:6 = 0.
- R6: When no candidate is taken, the code output is 0x31 and the divider output is all ones (0xFFFFFFFF).
- R7: The bus rate output equals the source frequency divided by the divider output, integer quotient.
- R8: `done` is high for exactly one cycle per request. All four result outputs change only in that cycle and hold their values otherwise.
- R9: A `start` pulse that arrives while a request is in progress is ignored. The frequencies used are the ones present with the accepted `start`.
- R10: While reset is active and after it is released, `done` is low and all result outputs are zero until the first request completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; captures both frequencies |
| src_hz | input | 32 | Source clock frequency in Hz |
| bus_hz | input | 32 | Requested bus rate in Hz |
| done | output | 1 | One-cycle completion pulse |
| fd_code | output | 8 | Packed prescaler code |
| filt_val | output | 8 | Filter sampling value |
| div_sel | output | 32 | Divider of the chosen pair |
| bus_rate | output | 32 | Resulting bus rate in Hz |

## Verification
A low source clock with a zero filter value shows that the candidates reduce to plain products and that the smallest pair is found. A source clock high enough to give a nonzero correction term shows that the term is added for the small fine steps and drops out for the large ones. A target that equals a candidate exactly separates strict from non-strict comparison, and a tie between two pairs with the same divider shows which pair is kept. A huge ratio and a zero bus rate both saturate the target and exercise the fallback code. A second `start` sent during a run, and input changes made between runs, show that captured operands are used and that the outputs hold.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TGT,
      ST_FLT,
      ST_SRCH,
      ST_SPD
   } srch_st_e;

   // Code layout: [5] coarse bit 2, [4:2] fine index, [1:0] coarse bits 1:0
   function automatic logic [7:0] pack_code(input logic [2:0] ga, input logic [2:0] gb);
      return {2'b00, ga[2], gb, ga[1:0]};
   endfunction

endpackage

// File: rtl/sclk_seq_div.sv
module sclk_seq_div #(
   parameter int W = 32,
   localparam int CW = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic         fin
);

   logic [W-1:0]  rem_q;
   logic [W-1:0]  quo_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    shifted;
   logic [W:0]    diff;
   logic          ge;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      ge      = shifted >= {1'b0, den};
      diff    = shifted - {1'b0, den};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (run_q) begin
            quo_q <= {quo_q[W-2:0], ge};
            rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
            end
         end else if (go) begin
            quo_q <= num;
            rem_q <= '0;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end
      end
   end

   assign quo = quo_q;

endmodule

// File: rtl/sclk_cand_gen.sv
module sclk_cand_gen #(
   parameter int W       = 32,
   parameter int AW      = 5,
   parameter int GBW     = 3,
   parameter int FLT_W   = 8,
   parameter int B_SHIFT = 4
) (
   input  logic [AW-1:0]    a_val,
   input  logic [GBW-1:0]   gb,
   input  logic [FLT_W-1:0] filt,
   output logic [W-1:0]     cdiv
);

   logic [7:0]   sh;
   logic [W-1:0] f3;
   logic [W-1:0] corr;
   logic [W-1:0] base;

   always_comb begin
      sh   = 8'(B_SHIFT) + 8'(gb);
      f3   = W'(filt) * W'(3);
      corr = f3 >> sh;
      base = W'(a_val) + (corr << 1);
      cdiv = base << sh;
   end

endmodule

// File: rtl/sclk_div_search.sv
module sclk_div_search
   import sclk_div_pkg::*;
#(
   parameter int         CLK_W     = 32,
   parameter int         TGT_W     = 16,
   parameter int         FLT_W     = 8,
   parameter int         A_FIRST   = 10,
   parameter int         A_LAST    = 30,
   parameter int         A_STEP    = 2,
   parameter int         GA_FIRST  = 4,
   parameter int         GB_CNT    = 8,
   parameter int         B_SHIFT   = 4,
   parameter int         FLT_RATIO = 20_000_000,
   parameter logic [7:0] DEF_CODE  = 8'h31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CLK_W-1:0] src_hz,
   input  logic [CLK_W-1:0] bus_hz,
   output logic             done,
   output logic [7:0]       fd_code,
   output logic [FLT_W-1:0] filt_val,
   output logic [CLK_W-1:0] div_sel,
   output logic [CLK_W-1:0] bus_rate
);

   localparam int AW  = $clog2(A_LAST + 1);
   localparam int GBW = $clog2(GB_CNT);

   // Elaboration checks
   if (A_LAST < A_FIRST)           begin : g_chk_a    $error("A_LAST below A_FIRST"); end
   if ((A_LAST - A_FIRST) % A_STEP != 0) begin : g_chk_step $error("A range not a step multiple"); end
   if (GB_CNT < 2 || GB_CNT > 8 || (1 << GBW) != GB_CNT) begin : g_chk_gb $error("GB_CNT must be 2, 4 or 8"); end
   if (FLT_W > CLK_W || TGT_W > CLK_W) begin : g_chk_w  $error("result widths exceed CLK_W"); end

   srch_st_e         st_q;
   logic [CLK_W-1:0] src_q;
   logic [CLK_W-1:0] div_den;
   logic             div_go;
   logic [CLK_W-1:0] quo;
   logic             fin;
   logic [TGT_W-1:0] tgt_q;
   logic [FLT_W-1:0] filt_q;
   logic [CLK_W-1:0] best_q;
   logic [7:0]       code_q;
   logic [AW-1:0]    a_q;
   logic [2:0]       ga_q;
   logic [GBW-1:0]   gb_q;
   logic [CLK_W-1:0] cdiv;
   logic             take;
   logic [TGT_W-1:0] tgt_sat;
   logic [FLT_W-1:0] filt_sat;

   sclk_seq_div #(.W(CLK_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go),
      .num  (src_q),
      .den  (div_den),
      .quo  (quo),
      .fin  (fin)
   );

   sclk_cand_gen #(
      .W      (CLK_W),
      .AW     (AW),
      .GBW    (GBW),
      .FLT_W  (FLT_W),
      .B_SHIFT(B_SHIFT)
   ) u_cand (
      .a_val(a_q),
      .gb   (gb_q),
      .filt (filt_q),
      .cdiv (cdiv)
   );

   // Saturating narrowing of quotients
   if (TGT_W < CLK_W) begin : g_tgt_sat
      assign tgt_sat = (|quo[CLK_W-1:TGT_W]) ? '1 : quo[TGT_W-1:0];
   end else begin : g_tgt_pass
      assign tgt_sat = quo;
   end

   if (FLT_W < CLK_W) begin : g_flt_sat
      assign filt_sat = (|quo[CLK_W-1:FLT_W]) ? '1 : quo[FLT_W-1:0];
   end else begin : g_flt_pass
      assign filt_sat = quo;
   end

   assign take = (cdiv > CLK_W'(tgt_q)) && (cdiv < best_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         src_q    <= '0;
         div_den  <= '0;
         div_go   <= 1'b0;
         tgt_q    <= '0;
         filt_q   <= '0;
         best_q   <= '0;
         code_q   <= '0;
         a_q      <= '0;
         ga_q     <= '0;
         gb_q     <= '0;
         done     <= 1'b0;
         fd_code  <= '0;
         filt_val <= '0;
         div_sel  <= '0;
         bus_rate <= '0;
      end else begin
         div_go <= 1'b0;
         done   <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  src_q   <= src_hz;
                  div_den <= bus_hz;
                  div_go  <= 1'b1;
                  st_q    <= ST_TGT;
               end
            end
            ST_TGT: begin
               if (fin) begin
                  tgt_q   <= tgt_sat;
                  div_den <= CLK_W'(FLT_RATIO);
                  div_go  <= 1'b1;
                  st_q    <= ST_FLT;
               end
            end
            ST_FLT: begin
               if (fin) begin
                  filt_q <= filt_sat;
                  best_q <= '1;
                  code_q <= DEF_CODE;
                  a_q    <= AW'(A_FIRST);
                  ga_q   <= 3'(GA_FIRST);
                  gb_q   <= '0;
                  st_q   <= ST_SRCH;
               end
            end
            ST_SRCH: begin
               if (take) begin
                  best_q <= cdiv;
                  code_q <= pack_code(ga_q, 3'(gb_q));
               end
               if (gb_q == GBW'(GB_CNT - 1)) begin
                  gb_q <= '0;
                  if (a_q == AW'(A_LAST)) begin
                     div_den <= take ? cdiv : best_q;
                     div_go  <= 1'b1;
                     st_q    <= ST_SPD;
                  end else begin
                     a_q  <= a_q + AW'(A_STEP);
                     ga_q <= ga_q + 3'd1;
                  end
               end else begin
                  gb_q <= gb_q + 1'b1;
               end
            end
            ST_SPD: begin
               if (fin) begin
                  fd_code  <= code_q;
                  filt_val <= filt_q;
                  div_sel  <= best_q;
                  bus_rate <= quo;
                  done     <= 1'b1;
                  st_q     <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sclk_div_search_chk.sv
module sclk_div_search_chk #(
   parameter int         CLK_W    = 32,
   parameter int         FLT_W    = 8,
   parameter int         B_SHIFT  = 4,
   parameter logic [7:0] DEF_CODE = 8'h31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic [7:0]       fd_code,
   input logic [FLT_W-1:0] filt_val,
   input logic [CLK_W-1:0] div_sel,
   input logic [CLK_W-1:0] bus_rate
);

   // R8: completion is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: results move only together with done
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(fd_code) && $stable(filt_val) && $stable(div_sel) && $stable(bus_rate)));

   // R6: an all-ones divider comes only with the fallback code
   p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (div_sel == '1)) |-> (fd_code == DEF_CODE));

   // R3 and R5: the chosen divider is a multiple of the fine step named in the code
   p_fine_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (div_sel != '1)) |->
         ((div_sel & ((CLK_W'(1) << (B_SHIFT + int'(fd_code[4:2]))) - CLK_W'(1))) == '0));

   // R5: upper code bits stay clear
   p_code_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fd_code[7:6] == 2'b00));

endmodule

bind sclk_div_search sclk_div_search_chk #(
   .CLK_W   (CLK_W),
   .FLT_W   (FLT_W),
   .B_SHIFT (B_SHIFT),
   .DEF_CODE(DEF_CODE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .fd_code (fd_code),
   .filt_val(filt_val),
   .div_sel (div_sel),
   .bus_rate(bus_rate)
);

// File: tb/test_sclk_div_search.sv
`timescale 1ns/1ps
module test_sclk_div_search;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] src_hz = '0;
   logic [31:0] bus_hz = '0;
   logic        done;
   logic [7:0]  fd_code;
   logic [7:0]  filt_val;
   logic [31:0] div_sel;
   logic [31:0] bus_rate;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   sclk_div_search i_sclk_div_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .src_hz  (src_hz),
      .bus_hz  (bus_hz),
      .done    (done),
      .fd_code (fd_code),
      .filt_val(filt_val),
      .div_sel (div_sel),
      .bus_rate(bus_rate)
   );

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL R8 watchdog: got no completion, expected end before 100000 cycles");
         summary();
      end
   end

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // Reference from the requirements
   task automatic model(input logic [31:0] s, input logic [31:0] b,
                        output logic [7:0] e_code, output logic [7:0] e_filt,
                        output logic [31:0] e_div, output logic [31:0] e_rate);
      longint t, f, best, c, bb;
      logic [7:0] code;
      if (b == 0) t = 65535;
      else t = longint'(s) / longint'(b);
      if (t > 65535) t = 65535;
      f = longint'(s) / 20000000;
      if (f > 255) f = 255;
      best = 64'hFFFF_FFFF;
      code = 8'h31;
      for (int ai = 0; ai < 11; ai++) begin
         for (int g = 0; g < 8; g++) begin
            longint a;
            int ga;
            a  = 10 + 2 * ai;
            ga = 4 + ai;
            bb = longint'(16) << g;
            c  = bb * (a + ((3 * f) / bb) * 2);
            if (c > t && c < best) begin
               best = c;
               code = 8'((g << 2) | (ga & 3) | ((ga & 4) << 3));
            end
         end
      end
      e_code = code;
      e_filt = 8'(f);
      e_div  = 32'(best);
      e_rate = 32'(longint'(s) / best);
   endtask

   task automatic wait_done(input string tag);
      int n = 0;
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " done seen"}, 64'(done), 64'd1);
   endtask

   task automatic check_out(input string tag, input logic [31:0] s, input logic [31:0] b);
      logic [7:0]  e_code, e_filt;
      logic [31:0] e_div, e_rate;
      model(s, b, e_code, e_filt, e_div, e_rate);
      chk({tag, " R5 code"},     64'(fd_code),  64'(e_code));
      chk({tag, " R2 filter"},   64'(filt_val), 64'(e_filt));
      chk({tag, " R4 divider"},  64'(div_sel),  64'(e_div));
      chk({tag, " R7 bus rate"}, 64'(bus_rate), 64'(e_rate));
   endtask

   task automatic run_case(input string tag, input logic [31:0] s, input logic [31:0] b);
      @(negedge clk);
      start  = 1'b1;
      src_hz = s;
      bus_hz = b;
      @(negedge clk);
      start = 1'b0;
      wait_done(tag);
      check_out(tag, s, b);
      @(negedge clk);
      chk({tag, " R8 pulse ends"}, 64'(done), 64'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 done in reset", 64'(done), 64'd0);
      chk("R10 outputs in reset", {fd_code, filt_val, div_sel[15:0], bus_rate[15:0]}, 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 outputs after release", {16'd0, div_sel, fd_code, filt_val}, 64'd0);
   endtask

   task automatic t_plain();
      run_case("R3 plain 100M/100k", 32'd100_000_000, 32'd100_000);
      chk("R3 plain divider value", 64'(div_sel), 64'd1024);
      chk("R5 plain code value", 64'(fd_code), 64'h2B);
   endtask

   task automatic t_corr();
      run_case("R3 corrected 400M/400k", 32'd400_000_000, 32'd400_000);
      run_case("R3 corrected 300M/1M", 32'd300_000_000, 32'd1_000_000);
      run_case("R1 low 33M/10k", 32'd33_000_000, 32'd10_000);
   endtask

   task automatic t_edges();
      run_case("R4 exact target 160", 32'd160_000, 32'd1_000);
      chk("R4 exact target rejected", 64'(div_sel), 64'd192);
      chk("R5 exact target code", 64'(fd_code), 64'h21);
      run_case("R4 tie at 320", 32'd310_000, 32'd1_000);
      chk("R4 tie keeps first pair", 64'(fd_code), 64'h24);
      run_case("R5 smallest pair", 32'd1_000_000, 32'd1_000_000);
      chk("R5 smallest code", 64'(fd_code), 64'h20);
   endtask

   task automatic t_nomatch();
      run_case("R6 saturated ratio", 32'd4_000_000_000, 32'd1);
      chk("R6 fallback code", 64'(fd_code), 64'h31);
      chk("R6 fallback divider", 64'(div_sel), 64'hFFFF_FFFF);
      run_case("R1 zero bus rate", 32'd50_000_000, 32'd0);
      chk("R1 zero bus fallback", 64'(fd_code), 64'h31);
   endtask

   task automatic t_busy();
      int extra = 0;
      @(negedge clk);
      start  = 1'b1;
      src_hz = 32'd100_000_000;
      bus_hz = 32'd100_000;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      start  = 1'b1;
      src_hz = 32'd400_000_000;
      bus_hz = 32'd400_000;
      @(negedge clk);
      start = 1'b0;
      wait_done("R9 busy");
      check_out("R9 first operands kept", 32'd100_000_000, 32'd100_000);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk("R9 second start ignored", 64'(extra), 64'd0);
   endtask

   task automatic t_hold();
      logic [7:0]  c0;
      logic [31:0] d0;
      c0 = fd_code;
      d0 = div_sel;
      src_hz = 32'd7;
      bus_hz = 32'd3;
      repeat (50) @(negedge clk);
      chk("R8 code held", 64'(fd_code), 64'(c0));
      chk("R8 divider held", 64'(div_sel), 64'(d0));
   endtask

   initial begin
      t_reset();
      t_plain();
      t_corr();
      t_edges();
      t_nomatch();
      t_busy();
      t_hold();
      summary();
   end

endmodule